// File: doc/BRIEF.md
# Handshake-to-Serial Byte Bridge

This block connects a self-timed processor port to a half-duplex serial line. On the host side there are two four-phase request/acknowledge channels, each carrying a byte as bundled data. One channel is for bytes the host sends and the other is for bytes the host fetches. On the line side each byte travels as a ten-bit frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. One bit is sent or sampled per bit period.

The block runs from a fast carrier clock. A bit-rate enable is produced every `DIV` carrier cycles; the default is 16. Request inputs are asynchronous, so they pass through two flip-flops before the handshake logic sees them. When the reception-enable input `rx_mode` is high, the line receiver is armed. When it is low, the transmitter may start frames. Each direction has a one-byte holding register, so the host can hand over or collect one byte while the serial engine is busy with another. If a received byte is not collected before the next one completes, the new byte replaces the old one and a flag records the loss.

Top module: `hsb_bridge`

## Requirements
- R1: After reset, `line_out` is 1, and `tx_ack`, `rx_ack`, `overrun` and `frame_err` are 0.
- R2: `tx_ack` rises only while `tx_req` has been high. It rises no earlier than the third rising clock edge after `tx_req` is raised, and only when the send holding register is empty. It falls only after `tx_req` has returned to 0. `tx_data` is captured when `tx_ack` rises.
- R3: A sent frame is a 0 start bit, then data bits 0 through 7, then a 1 stop bit. Each bit lasts `DIV` clock cycles. Whenever no frame is in progress, `line_out` is 1.
- R4: No new frame starts while `rx_mode` is 1. A byte accepted in that state is held, and it is sent once `rx_mode` returns to 0.
- R5: The send holding register frees as soon as its byte is loaded into the shifter. A second byte is therefore acknowledged while the first is still on the line.
- R6: When `rx_mode` is 1, a frame with a valid stop bit yields its byte. `rx_req` is answered by `rx_ack` with that byte on `rx_data`. `rx_data` stays stable while `rx_ack` is high, and `rx_ack` falls after `rx_req` returns to 0.
- R7: A receive request made while no byte is held is not acknowledged until a frame completes. That frame's byte is then delivered.
- R8: Frames that begin on `line_in` while `rx_mode` is 0 are ignored and deliver no byte.
- R9: A received byte that completes while an unread byte is held overwrites the held byte and sets `overrun`. The next host read returns the newer byte and clears `overrun`.
- R10: A frame whose stop bit samples as 0 is discarded and sets `frame_err`. `frame_err` then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_mode | input | 1 | 1 arms the receiver; 0 lets the transmitter start frames |
| tx_req | input | 1 | Host send request, four-phase |
| tx_data | input | DW | Byte to send, valid while `tx_req` is high |
| tx_ack | output | 1 | Send acknowledge |
| rx_req | input | 1 | Host receive request, four-phase |
| rx_data | output | DW | Received byte, valid while `rx_ack` is high |
| rx_ack | output | 1 | Receive acknowledge |
| line_in | input | 1 | Serial input from the demodulator |
| line_out | output | 1 | Serial output to the load modulator |
| overrun | output | 1 | An unread received byte was overwritten |
| frame_err | output | 1 | Sticky flag: a frame arrived with a bad stop bit |

## Verification
Every one of the 256 byte values is pushed through each direction. Mirrored or shifted bit order would show up as a mismatch on asymmetric values, and a stuck data bit would corrupt half of the sweep. Two writes issued back to back show whether the holding register frees on load rather than at the end of the frame. A send issued while receiving shows that frame starts are gated.

On the receive side, several directed patterns are used:
- A request raised before any frame shows that the read stalls.
- Two frames with no read in between show the overwrite and the overrun flag.
- A zero stop bit shows that the frame is dropped and the error flag stays set.
- A frame sent while the receiver is disarmed shows that it is ignored.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [1:0] {
    LN_IDLE = 2'd0,
    LN_DATA = 2'd1,
    LN_STOP = 2'd2
  } ln_state_t;
endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/hsb_tick.sv
module hsb_tick #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;

  assign tick = (cnt_q == TW'(DIV - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hsb_line_tx.sv
module hsb_line_tx
  import hsb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          go,
  input  logic [DW-1:0] data,
  output logic          taken,
  output logic          busy,
  output logic          line
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  ln_state_t     st_q, st_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          line_q, line_d;

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    line_d = line_q;
    taken  = 1'b0;
    if (tick) begin
      case (st_q)
        LN_IDLE: if (go) begin
          taken  = 1'b1;
          sh_d   = data;
          cnt_d  = '0;
          line_d = 1'b0;
          st_d   = LN_DATA;
        end
        LN_DATA: begin
          line_d = sh_q[0];
          sh_d   = sh_q >> 1;
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == CW'(DW - 1)) st_d = LN_STOP;
        end
        LN_STOP: begin
          line_d = 1'b1;
          st_d   = LN_IDLE;
        end
        default: st_d = LN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LN_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      line_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      line_q <= line_d;
    end
  end

  assign busy = (st_q != LN_IDLE);
  assign line = line_q;
endmodule

// File: rtl/hsb_line_rx.sv
module hsb_line_rx
  import hsb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          line,
  output logic          done,
  output logic          bad,
  output logic [DW-1:0] word
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  ln_state_t     st_q, st_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    sh_d  = sh_q;
    cnt_d = cnt_q;
    done  = 1'b0;
    bad   = 1'b0;
    if (tick) begin
      case (st_q)
        LN_IDLE: if (en && !line) begin
          cnt_d = '0;
          st_d  = LN_DATA;
        end
        LN_DATA: begin
          sh_d  = {line, sh_q[DW-1:1]};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(DW - 1)) st_d = LN_STOP;
        end
        LN_STOP: begin
          done = line;
          bad  = !line;
          st_d = LN_IDLE;
        end
        default: st_d = LN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LN_IDLE;
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign word = sh_q;
endmodule

// File: rtl/hsb_bridge.sv
module hsb_bridge #(
  parameter int DW  = 8,
  parameter int DIV = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_mode,
  input  logic          tx_req,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ack,
  input  logic          rx_req,
  output logic [DW-1:0] rx_data,
  output logic          rx_ack,
  input  logic          line_in,
  output logic          line_out,
  output logic          overrun,
  output logic          frame_err
);
  logic          rst_sync_n;
  logic [1:0]    req_s;
  logic          tx_req_s, rx_req_s;
  logic          tick;
  logic          tx_go, tx_taken, tx_busy;
  logic          rx_done, rx_bad;
  logic [DW-1:0] rx_word;

  logic          tx_ack_q, tx_ack_d, tx_full_q, tx_full_d;
  logic [DW-1:0] tx_buf_q, tx_buf_d;
  logic          rx_ack_q, rx_ack_d, rx_full_q, rx_full_d;
  logic [DW-1:0] rx_buf_q, rx_buf_d, rx_out_q, rx_out_d;
  logic          ovr_q, ovr_d, ferr_q, ferr_d;
  logic          accept, fetch;

  hsb_sync #(.W(1)) u_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  hsb_sync #(.W(2)) u_req (
    .clk(clk), .rst_n(rst_sync_n), .d({tx_req, rx_req}), .q(req_s)
  );
  assign tx_req_s = req_s[1];
  assign rx_req_s = req_s[0];

  hsb_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick)
  );

  assign tx_go = tx_full_q && !rx_mode;

  hsb_line_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .go(tx_go),
    .data(tx_buf_q), .taken(tx_taken), .busy(tx_busy), .line(line_out)
  );

  hsb_line_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .en(rx_mode),
    .line(line_in), .done(rx_done), .bad(rx_bad), .word(rx_word)
  );

  assign accept = tx_req_s && !tx_ack_q && !tx_full_q;
  assign fetch  = rx_req_s && !rx_ack_q && rx_full_q;

  always_comb begin
    tx_ack_d  = tx_ack_q;
    tx_full_d = tx_full_q;
    tx_buf_d  = tx_buf_q;
    if (accept) begin
      tx_ack_d  = 1'b1;
      tx_full_d = 1'b1;
      tx_buf_d  = tx_data;
    end else begin
      if (!tx_req_s) tx_ack_d  = 1'b0;
      if (tx_taken)  tx_full_d = 1'b0;
    end
  end

  always_comb begin
    rx_ack_d  = rx_ack_q;
    rx_full_d = rx_full_q;
    rx_buf_d  = rx_buf_q;
    rx_out_d  = rx_out_q;
    ovr_d     = ovr_q;
    ferr_d    = ferr_q || rx_bad;
    if (fetch) begin
      rx_ack_d  = 1'b1;
      rx_out_d  = rx_buf_q;
      rx_full_d = 1'b0;
      ovr_d     = 1'b0;
    end else if (!rx_req_s) begin
      rx_ack_d  = 1'b0;
    end
    if (rx_done) begin
      rx_buf_d  = rx_word;
      rx_full_d = 1'b1;
      if (rx_full_q && !fetch) ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tx_ack_q  <= 1'b0;
      tx_full_q <= 1'b0;
      tx_buf_q  <= '0;
      rx_ack_q  <= 1'b0;
      rx_full_q <= 1'b0;
      rx_buf_q  <= '0;
      rx_out_q  <= '0;
      ovr_q     <= 1'b0;
      ferr_q    <= 1'b0;
    end else begin
      tx_ack_q  <= tx_ack_d;
      tx_full_q <= tx_full_d;
      tx_buf_q  <= tx_buf_d;
      rx_ack_q  <= rx_ack_d;
      rx_full_q <= rx_full_d;
      rx_buf_q  <= rx_buf_d;
      rx_out_q  <= rx_out_d;
      ovr_q     <= ovr_d;
      ferr_q    <= ferr_d;
    end
  end

  assign tx_ack    = tx_ack_q;
  assign rx_ack    = rx_ack_q;
  assign rx_data   = rx_out_q;
  assign overrun   = ovr_q;
  assign frame_err = ferr_q;
endmodule

// File: rtl/hsb_bridge_chk.sv
module hsb_bridge_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_req,
  input logic          tx_ack,
  input logic          rx_ack,
  input logic [DW-1:0] rx_data,
  input logic          line_out,
  input logic          tx_busy,
  input logic          overrun,
  input logic          frame_err
);
  AST_TX_ACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ack) |-> $past(tx_req)); // R2

  AST_TX_ACK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ack) |-> !$past(tx_req)); // R2

  AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> line_out); // R3

  AST_RX_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && $past(rx_ack)) |-> $stable(rx_data)); // R6

  AST_OVERRUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ack) |-> !overrun); // R9

  AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_err) |-> frame_err); // R10
endmodule

bind hsb_bridge hsb_bridge_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tx_req(tx_req), .tx_ack(tx_ack),
  .rx_ack(rx_ack), .rx_data(rx_data), .line_out(line_out),
  .tx_busy(tx_busy), .overrun(overrun), .frame_err(frame_err)
);

// File: tb/test_hsb_bridge.sv
`timescale 1ns/1ps
module test_hsb_bridge;
  localparam int DW  = 8;
  localparam int DIV = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx_mode;
  logic          tx_req;
  logic [DW-1:0] tx_data;
  logic          tx_ack;
  logic          rx_req;
  logic [DW-1:0] rx_data;
  logic          rx_ack;
  logic          line_in;
  logic          line_out;
  logic          overrun;
  logic          frame_err;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  logic [7:0] cap_mem [0:511];
  int         cap_cnt = 0;

  always #2 clk = ~clk;

  hsb_bridge #(.DW(DW), .DIV(DIV)) i_hsb_bridge (
    .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode),
    .tx_req(tx_req), .tx_data(tx_data), .tx_ack(tx_ack),
    .rx_req(rx_req), .rx_data(rx_data), .rx_ack(rx_ack),
    .line_in(line_in), .line_out(line_out),
    .overrun(overrun), .frame_err(frame_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Line monitor: captures frames leaving line_out (R3)
  initial begin
    forever begin
      @(negedge clk);
      if (line_out === 1'b0) begin
        logic [7:0] b;
        repeat (DIV/2) @(negedge clk);
        chk(line_out === 1'b0, "R3 start bit", line_out, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (DIV) @(negedge clk);
          b[i] = line_out;
        end
        repeat (DIV) @(negedge clk);
        chk(line_out === 1'b1, "R3 stop bit", line_out, 1);
        cap_mem[cap_cnt] = b;
        cap_cnt++;
      end
    end
  end

  task automatic drive_bit(input logic v);
    line_in = v;
    repeat (DIV) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    @(negedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(b[i]);
    drive_bit(stop);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic host_write(input logic [7:0] b);
    int n;
    @(negedge clk);
    tx_data = b;
    tx_req  = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx_ack == 1'b0, "R2 ack after sync", tx_ack, 0);
    n = 0;
    while (!tx_ack && n < 4000) begin @(negedge clk); n++; end
    chk(tx_ack == 1'b1, "R2 ack rise", tx_ack, 1);
    tx_req = 1'b0;
    n = 0;
    while (tx_ack && n < 100) begin @(negedge clk); n++; end
    chk(tx_ack == 1'b0, "R2 ack fall", tx_ack, 0);
  endtask

  task automatic host_read(input int tmo, output logic got, output logic [7:0] b);
    int n;
    @(negedge clk);
    rx_req = 1'b1;
    n = 0;
    while (!rx_ack && n < tmo) begin @(negedge clk); n++; end
    got = rx_ack;
    b   = rx_data;
    if (got) begin
      repeat (3) @(negedge clk);
      chk(rx_data == b, "R6 data held", rx_data, b);
    end
    rx_req = 1'b0;
    n = 0;
    while (rx_ack && n < 100) begin @(negedge clk); n++; end
    if (got) chk(rx_ack == 1'b0, "R6 ack fall", rx_ack, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_caps(input int target);
    int n = 0;
    while (cap_cnt < target && n < 40000) begin @(negedge clk); n++; end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!ended) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic       got;
    logic [7:0] b;
    int         base;

    rst_n = 1'b0; rx_mode = 1'b0; tx_req = 1'b0; tx_data = '0;
    rx_req = 1'b0; line_in = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(line_out == 1'b1, "R1 line_out", line_out, 1);
    chk(tx_ack == 1'b0,   "R1 tx_ack", tx_ack, 0);
    chk(rx_ack == 1'b0,   "R1 rx_ack", rx_ack, 0);
    chk(overrun == 1'b0,  "R1 overrun", overrun, 0);
    chk(frame_err == 1'b0,"R1 frame_err", frame_err, 0);

    // R5: second byte accepted while first is still on the line
    base = cap_cnt;
    host_write(8'hA1);
    host_write(8'h5E);
    chk(cap_cnt == base, "R5 second ack during first frame", cap_cnt, base);
    wait_caps(base + 2);
    chk(cap_mem[base] == 8'hA1,   "R5 first byte", cap_mem[base], 8'hA1);
    chk(cap_mem[base+1] == 8'h5E, "R5 second byte", cap_mem[base+1], 8'h5E);

    // R4: no frame start while receiving
    repeat (20) @(negedge clk);
    rx_mode = 1'b1;
    base = cap_cnt;
    host_write(8'hC3);
    repeat (20 * DIV) begin
      @(negedge clk);
      if (line_out !== 1'b1) break;
    end
    chk(line_out == 1'b1, "R4 line idle in rx mode", line_out, 1);
    chk(cap_cnt == base, "R4 no frame in rx mode", cap_cnt, base);
    rx_mode = 1'b0;
    wait_caps(base + 1);
    chk(cap_mem[base] == 8'hC3, "R4 held byte sent", cap_mem[base], 8'hC3);

    // R3: exhaustive send sweep
    base = cap_cnt;
    for (int v = 0; v < 256; v++) host_write(v[7:0]);
    wait_caps(base + 256);
    chk(cap_cnt == base + 256, "R3 frame count", cap_cnt, base + 256);
    for (int v = 0; v < 256; v++)
      chk(cap_mem[base+v] == v[7:0], "R3 sent byte", cap_mem[base+v], v);

    // R7: read waits for a frame
    repeat (20 * DIV) @(negedge clk);
    rx_mode = 1'b1;
    repeat (4) @(negedge clk);
    fork
      begin
        repeat (10) @(negedge clk);
        send_frame(8'h96, 1'b1);
      end
      begin
        repeat (20) @(negedge clk);
        chk(rx_ack == 1'b0, "R7 no ack before frame", rx_ack, 0);
      end
      host_read(400, got, b);
    join
    chk(got == 1'b1, "R7 ack after frame", got, 1);
    chk(b == 8'h96,  "R7 byte", b, 8'h96);

    // R6: exhaustive receive sweep
    for (int v = 0; v < 256; v++) begin
      send_frame(v[7:0], 1'b1);
      host_read(100, got, b);
      chk(got == 1'b1, "R6 ack", got, 1);
      chk(b == v[7:0], "R6 byte", b, v);
      chk(overrun == 1'b0, "R9 no overrun", overrun, 0);
    end

    // R9: overwrite of unread byte
    send_frame(8'h11, 1'b1);
    chk(overrun == 1'b0, "R9 single byte", overrun, 0);
    send_frame(8'h22, 1'b1);
    chk(overrun == 1'b1, "R9 overrun set", overrun, 1);
    host_read(100, got, b);
    chk(b == 8'h22, "R9 newer byte kept", b, 8'h22);
    chk(overrun == 1'b0, "R9 overrun cleared", overrun, 0);

    // R10: bad stop bit
    chk(frame_err == 1'b0, "R10 clear before", frame_err, 0);
    send_frame(8'h5A, 1'b0);
    chk(frame_err == 1'b1, "R10 set", frame_err, 1);
    host_read(60, got, b);
    chk(got == 1'b0, "R10 frame dropped", got, 0);
    send_frame(8'h3C, 1'b1);
    host_read(100, got, b);
    chk(b == 8'h3C, "R10 next frame ok", b, 8'h3C);
    chk(frame_err == 1'b1, "R10 sticky", frame_err, 1);

    // R8: frames ignored while receiver disarmed
    rx_mode = 1'b0;
    send_frame(8'hA5, 1'b1);
    rx_mode = 1'b1;
    host_read(60, got, b);
    chk(got == 1'b0, "R8 ignored frame", got, 0);
    send_frame(8'h4B, 1'b1);
    host_read(100, got, b);
    chk(b == 8'h4B, "R8 armed frame", b, 8'h4B);

    ended = 1'b1;
    summary();
    $finish;
  end
endmodule